// File: doc/BRIEF.md
# Processor Status Flags Register

This block holds a 32-bit processor status word and keeps its four condition flags current. Each cycle the execution unit may present an operation class, the sign bits of both operands, the 32-bit result and the adder's carry/borrow output. When a flag update is requested, the block derives negative, zero, carry and signed-overflow bits from these and stores them in the top nibble of the word. A separate full-word write port lets software load the register directly.

The low byte is the control field. It holds an interrupt mask, a fast-interrupt mask, a state bit and a 5-bit mode field. Software may change it only while the current mode is privileged, and flag updates never touch it. Bits 27:8 are reserved: they read as zero and ignore every write. The stored word is the output, so readers see the value one clock after it was written.

Top module: `psr_unit`

## Requirements
- R1: A synchronous active-low reset loads 0x000000D3: flags clear, interrupt mask (bit 7) = 1, fast-interrupt mask (bit 6) = 1, state bit (bit 5) = 0, mode (bits 4:0) = 5'b10011.
- R2: Bits 27:8 of `psr_q` read as zero at all times, including after a software write of all ones.
- R3: On a flag update (`flag_en` = 1 and `sw_wr_en` = 0), bit 31 (negative) takes bit 31 of `alu_res` on the next clock.
- R4: On a flag update, bit 30 (zero) becomes 1 when `alu_res` is all zeros and 0 otherwise.
- R5: With `op_sel` = 2'b00 (add), bit 29 (carry) becomes `alu_carry`, the unsigned carry out of bit 31.
- R6: With `op_sel` = 2'b01 (subtract or compare), `alu_carry` is the borrow, and bit 29 stores its inverse: 1 when no borrow occurred. For example, 0x00000000 minus 0x000000FF gives 0xFFFFFF01 with carry 0.
- R7: For add, bit 28 (overflow) is set only when both operands share a sign and the result's sign differs from it. Operands of opposite sign never set it.
- R8: For subtract A−B, bit 28 is set only when A and B differ in sign and the result's sign differs from A's.
- R9: With `op_sel` = 2'b10 or 2'b11 (logical), a flag update changes only bits 31 and 30. Bits 29 and 28 keep their values.
- R10: A software write always loads bits 31:28 from `sw_wr_data`. It loads bits 7:0 only when the current mode field is not 5'b10000 (user). In user mode the control byte keeps its value.
- R11: When `sw_wr_en` and `flag_en` are both 1 in the same cycle, the software write wins and the flag computation is discarded.
- R12: Flag updates never change bits 7:0. With both enables low, the whole register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flag_en | input | 1 | Request a condition-flag update this cycle |
| op_sel | input | 2 | Operation class: 00 add, 01 subtract/compare, 10 or 11 logical |
| opnd_a_msb | input | 1 | Sign bit of the first operand |
| opnd_b_msb | input | 1 | Sign bit of the second operand |
| alu_res | input | 32 | Result of the operation |
| alu_carry | input | 1 | Carry out for add, borrow out for subtract |
| sw_wr_en | input | 1 | Software write strobe for the whole register |
| sw_wr_data | input | 32 | Value offered by the software write |
| psr_q | output | 32 | Current register contents |

## Verification
Every state bit is visible at `psr_q`, so a wrong flag or control value shows up at the next clock edge after the update that caused it. A corrupted mode field is the subtle case. It may look harmless until a later software write, which then changes the control byte when it should not, or fails to change it when it should. For that reason the bench mixes user-mode and privileged writes after flag activity. A bench model running alongside the design compares the full word every cycle, so one wrong bit is reported within a single clock.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
// Package psr_pkg
// Shared encodings for the status register: operation classes, field
// widths and the user-mode code that marks unprivileged execution.
package psr_pkg;

    // Operation classes presented by the execution unit.
    typedef enum logic [1:0] {
        OPK_ADD       = 2'b00,
        OPK_SUB       = 2'b01,
        OPK_LOGIC     = 2'b10,
        OPK_LOGIC_ALT = 2'b11
    } op_kind_e;

    localparam int CTRL_W = 8;   // control byte width
    localparam int FLAG_W = 4;   // condition flag count
    localparam int MODE_W = 5;   // mode field width

    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;

endpackage

// File: rtl/psr_flag_calc.sv
`timescale 1ns/1ps
// Module psr_flag_calc
// Combinational derivation of the four condition flags from one operation.
// Assumes: alu_res is the complete result; alu_carry is the adder carry for
// add and the borrow for subtract; only operand sign bits are needed.
module psr_flag_calc
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_kind_e            op,
    input  logic                a_msb,
    input  logic                b_msb,
    input  logic [DATA_W-1:0]   res,
    input  logic                carry_in,
    input  logic                c_cur,
    input  logic                v_cur,
    output logic                n_nxt,
    output logic                z_nxt,
    output logic                c_nxt,
    output logic                v_nxt
);

    logic r_msb;
    assign r_msb = res[DATA_W-1];

    // Purpose: sign and zero come from the result for every class.
    always_comb begin
        n_nxt = r_msb;
        z_nxt = ~|res;
    end

    // Purpose: carry and overflow depend on the operation class.
    always_comb begin
        unique case (op)
            OPK_ADD: begin
                c_nxt = carry_in;
                v_nxt = (a_msb == b_msb) && (r_msb != a_msb);
            end
            OPK_SUB: begin
                c_nxt = ~carry_in;
                v_nxt = (a_msb != b_msb) && (r_msb != a_msb);
            end
            default: begin
                c_nxt = c_cur;
                v_nxt = v_cur;
            end
        endcase
    end

endmodule

// File: rtl/psr_write_mask.sv
`timescale 1ns/1ps
// Module psr_write_mask
// Builds the per-bit enable for software writes: flags always writable,
// reserved bits never, control byte only outside user mode.
// Assumes: DATA_W leaves room for flags, reserved span and control byte.
module psr_write_mask
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [MODE_W-1:0]  cur_mode,
    output logic               priv,
    output logic [DATA_W-1:0]  wmask
);

    localparam int FLAG_LSB = DATA_W - FLAG_W;

    assign priv = (cur_mode != MODE_USER);

    // Purpose: assign each bit its write permission by field.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= FLAG_LSB)
                wmask[i] = 1'b1;
            else if (i < CTRL_W)
                wmask[i] = priv;
            else
                wmask[i] = 1'b0;
        end
    end

endmodule

// File: rtl/psr_unit.sv
`timescale 1ns/1ps
// Module psr_unit
// Status word register with flag update and privilege-gated software write.
// Assumes: the execution unit supplies a consistent result/carry pair;
// a software write takes precedence over a flag update in the same cycle.
module psr_unit
    import psr_pkg::*;
#(
    parameter int                 DATA_W       = 32,
    parameter logic [MODE_W-1:0]  RST_MODE     = 5'b10011,
    parameter logic               RST_IRQ_OFF  = 1'b1,
    parameter logic               RST_FIRQ_OFF = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flag_en,
    input  logic [1:0]         op_sel,
    input  logic               opnd_a_msb,
    input  logic               opnd_b_msb,
    input  logic [DATA_W-1:0]  alu_res,
    input  logic               alu_carry,
    input  logic               sw_wr_en,
    input  logic [DATA_W-1:0]  sw_wr_data,
    output logic [DATA_W-1:0]  psr_q
);

    localparam int N_BIT    = DATA_W - 1;
    localparam int Z_BIT    = DATA_W - 2;
    localparam int C_BIT    = DATA_W - 3;
    localparam int V_BIT    = DATA_W - 4;
    localparam int RSVD_HI  = V_BIT - 1;
    localparam int RSVD_LO  = CTRL_W;
    localparam logic [DATA_W-1:0] RESET_VAL =
        {{(DATA_W-CTRL_W){1'b0}}, RST_IRQ_OFF, RST_FIRQ_OFF, 1'b0, RST_MODE};

    logic               n_nxt, z_nxt, c_nxt, v_nxt;
    logic               priv;
    logic [DATA_W-1:0]  wmask;

    psr_flag_calc #(.DATA_W(DATA_W)) u_flags (
        .op       (op_kind_e'(op_sel)),
        .a_msb    (opnd_a_msb),
        .b_msb    (opnd_b_msb),
        .res      (alu_res),
        .carry_in (alu_carry),
        .c_cur    (psr_q[C_BIT]),
        .v_cur    (psr_q[V_BIT]),
        .n_nxt    (n_nxt),
        .z_nxt    (z_nxt),
        .c_nxt    (c_nxt),
        .v_nxt    (v_nxt)
    );

    psr_write_mask #(.DATA_W(DATA_W)) u_mask (
        .cur_mode (psr_q[MODE_W-1:0]),
        .priv     (priv),
        .wmask    (wmask)
    );

    // Purpose: hold the status word; write beats flag update beats hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psr_q <= RESET_VAL;
        else if (sw_wr_en)
            psr_q <= (sw_wr_data & wmask) | (psr_q & ~wmask);
        else if (flag_en)
            psr_q[N_BIT:V_BIT] <= {n_nxt, z_nxt, c_nxt, v_nxt};
    end

    // Purpose: marks cycles whose previous register value came from reset on.
    logic chk_armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed_q <= 1'b0;
        else        chk_armed_q <= 1'b1;
    end

    logic upd;
    assign upd = flag_en && !sw_wr_en;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        chk_armed_q |-> (psr_q[RSVD_HI:RSVD_LO] == '0));

    a_r3_neg_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (psr_q[N_BIT] == $past(alu_res[DATA_W-1])));

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (psr_q[Z_BIT] == ($past(alu_res) == '0)));

    a_r7_mixed_sign_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel == OPK_ADD && opnd_a_msb != opnd_b_msb) |=> !psr_q[V_BIT]);

    a_r8_same_sign_sub_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel == OPK_SUB && opnd_a_msb == opnd_b_msb) |=> !psr_q[V_BIT]);

    a_r9_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel[1]) |=> $stable(psr_q[C_BIT:V_BIT]));

    a_r10_user_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && $past(psr_q[MODE_W-1:0]) == MODE_USER) |-> $stable(psr_q[CTRL_W-1:0]));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (psr_q[N_BIT:V_BIT] == $past(sw_wr_data[N_BIT:V_BIT])));

    a_r12_flags_spare_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && upd) |=> $stable(psr_q[CTRL_W-1:0]));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed_q && !flag_en && !sw_wr_en) |=> $stable(psr_q));

endmodule

// File: tb/psr_unit_test.sv
`timescale 1ns/1ps
// Bench for psr_unit: behavioural reference model compared every clock.
module psr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        opnd_a_msb = 1'b0;
    logic        opnd_b_msb = 1'b0;
    logic [31:0] alu_res = '0;
    logic        alu_carry = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] psr_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q = '0;

    always #5 clk = ~clk;

    psr_unit uut (
        .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op_sel(op_sel),
        .opnd_a_msb(opnd_a_msb), .opnd_b_msb(opnd_b_msb), .alu_res(alu_res),
        .alu_carry(alu_carry), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .psr_q(psr_q)
    );

    // Reference: next word from the current word and one cycle of inputs.
    function automatic logic [31:0] model(logic [31:0] cur, logic fe, logic [1:0] op,
                                          logic [31:0] a, logic [31:0] b, logic [31:0] r,
                                          logic cy, logic we, logic [31:0] wd);
        logic [31:0] nv = cur;
        longint s;
        if (we) begin
            nv[31:28] = wd[31:28];
            nv[27:8]  = '0;
            if (cur[4:0] != 5'b10000) nv[7:0] = wd[7:0];
        end else if (fe) begin
            nv[31] = r[31];
            nv[30] = (r == 32'd0);
            if (op == 2'b00) begin
                s = longint'($signed(a)) + longint'($signed(b));
                nv[29] = cy;
                nv[28] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end else if (op == 2'b01) begin
                s = longint'($signed(a)) - longint'($signed(b));
                nv[29] = (a >= b);
                nv[28] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
        end
        return nv;
    endfunction

    task automatic compare(string req);
        n_cmp++;
        if (psr_q !== exp_q) begin
            n_bad++;
            $display("FAIL %s: psr_q actual %08h expected %08h", req, psr_q, exp_q);
        end
    endtask

    // Drive one cycle at a negedge, then compare at the following negedge.
    task automatic cycle(logic fe, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                         logic we, logic [31:0] wd, string req);
        logic [32:0] sum;
        logic [31:0] r;
        logic        cy;
        if (op == 2'b00) begin
            sum = {1'b0, a} + {1'b0, b};
            r = sum[31:0]; cy = sum[32];
        end else if (op == 2'b01) begin
            r = a - b; cy = (a < b);
        end else begin
            r = a & b; cy = a[0];
        end
        flag_en = fe; op_sel = op; opnd_a_msb = a[31]; opnd_b_msb = b[31];
        alu_res = r; alu_carry = cy; sw_wr_en = we; sw_wr_data = wd;
        exp_q = model(exp_q, fe, op, a, b, r, cy, we, wd);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; flag_en = 1'b0; sw_wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_q = 32'h0000_00D3;
        compare("R1");
        rst_n = 1'b1;
    endtask

    task automatic random_run(int count);
        for (int k = 0; k < count; k++) begin
            cycle(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom, $urandom,
                  ($urandom_range(0, 7) == 0), $urandom, "R3/R4/R5/R6/R7/R8/R9/R10/R11");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL all: watchdog actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cycle(0, 2'b00, 0, 0, 0, 0, "R12");
        cycle(1, 2'b00, 32'h7FFF_FFFF, 32'h1, 0, 0, "R3 R7");
        cycle(1, 2'b00, 32'hFFFF_FFFF, 32'h1, 0, 0, "R4 R5");
        cycle(1, 2'b00, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0, "R5 R7");
        cycle(1, 2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R7");
        cycle(1, 2'b01, 32'h0, 32'hFF, 0, 0, "R6");
        cycle(1, 2'b01, 32'h5, 32'h5, 0, 0, "R4 R6");
        cycle(1, 2'b01, 32'h8000_0000, 32'h1, 0, 0, "R8");
        cycle(1, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R8");
        cycle(1, 2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R8");
        cycle(1, 2'b10, 32'h0, 32'h0, 0, 0, "R9");
        cycle(1, 2'b11, 32'hF000_0000, 32'h8000_0001, 0, 0, "R9");
        cycle(0, 2'b01, 32'h0, 32'h1, 0, 0, "R12");
        cycle(0, 2'b00, 0, 0, 1, 32'hFFFF_FFFF, "R2 R10");
        cycle(1, 2'b00, 32'h0, 32'h0, 1, 32'h5000_00C5, "R11");
        cycle(1, 2'b00, 32'h1, 32'h1, 0, 0, "R12");
        cycle(0, 2'b00, 0, 0, 1, 32'h0000_0010, "R10");
        cycle(0, 2'b00, 0, 0, 1, 32'hA00F_F0D3, "R10 R2");
        cycle(1, 2'b01, 32'h0, 32'h1, 0, 0, "R12");
        cycle(1, 2'b01, 32'h3, 32'h3, 1, 32'h0000_00FF, "R10 R11");
        random_run(300);
        do_reset();
        random_run(300);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule